// File: doc/BRIEF.md
# Variable-Burst DRAM Command Sequencer

This block turns one memory request into the full command sequence a DRAM module needs: it opens a row, issues the column access, lets the data window run for as many beats as the request asks for, and closes the row again. It serves a memory controller that owns its module outright, so there is exactly one transaction in flight and no scheduling across banks. The controller presents a row address, a column address, a direction flag and a burst length together with a one-cycle start strobe while the sequencer is idle.

All timing limits are parameters counted in controller clock cycles: the delay from row open to column command, the column-access latency, the minimum time a row stays open, and the precharge time. The burst length arrives with each request and may be very long, so a whole message can move in one transaction. The sequencer reports the beat window and the current column address of each beat. It also gives a busy level and a one-cycle completion pulse.

Top module: `dram_burst_seq`

## Requirements
- R1: After reset, `busy`, `done`, `data_valid` and the three command strobes are all low.
- R2: A `start` seen while idle is accepted; `cmd_act` is high for one cycle in the next cycle with `cmd_addr` equal to the row address, and `busy` is high from that cycle until the cycle before `done`.
- R3: `cmd_col` is high for one cycle exactly `T_RCD` cycles after `cmd_act`, with `cmd_addr` equal to the column address (zero-extended).
- R4: `cmd_we` is high together with `cmd_col` when the request was a write (`wr_req`=1) and is low in every other cycle.
- R5: `data_valid` is high for exactly `burst_len` consecutive cycles, the first one `T_CL` cycles after `cmd_col`; a `burst_len` of 0 runs a single beat.
- R6: While `data_valid` is high, `beat_col` equals the start column plus the beat index (0 for the first beat), wrapping modulo 2^`COL_W`.
- R7: `cmd_pre` is high for one cycle, in the later of the cycle after the last beat and the cycle `T_RAS` cycles after `cmd_act`.
- R8: `done` is a one-cycle pulse `T_RP` cycles after `cmd_pre`, `busy` is low in that cycle, and a `start` presented in that cycle is accepted.
- R9: A `start` presented while `busy` is high is ignored: no extra command is issued and the running transaction keeps its addresses, direction and length.
- R10: The burst length may change from one transaction to the next and may be as long as 2^`BL_W`-1 beats, with no other change in behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request strobe |
| row_addr | input | ROW_W | Row to open |
| col_addr | input | COL_W | First column of the burst |
| wr_req | input | 1 | 1 = write, 0 = read |
| burst_len | input | BL_W | Number of beats (0 counts as 1) |
| cmd_act | output | 1 | Row-activate command strobe |
| cmd_col | output | 1 | Column-access command strobe |
| cmd_pre | output | 1 | Precharge command strobe |
| cmd_addr | output | max(ROW_W,COL_W) | Address sent with the current command |
| cmd_we | output | 1 | Write-enable, valid with the column command |
| data_valid | output | 1 | High for each data beat |
| beat_col | output | COL_W | Column of the current beat |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Burst lengths from zero up to well past the crossover point are swept for both reads and writes. Short bursts make the row-open minimum set the precharge cycle and long ones make the last beat set it, so a wrong choice of the later limit shows up. Start columns are chosen so that many bursts cross the top of the column range, which tells true wrapping apart from saturation. Transactions run back to back from the completion cycle, and strobes are injected mid-transaction with different addresses and direction, which separates an idle-only acceptance from a leaky one. Bursts of several hundred beats and of the largest encodable length show that the beat counter uses its full width.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ACT,
    ST_RCD,
    ST_COL,
    ST_CL,
    ST_BURST,
    ST_RAS,
    ST_PRE,
    ST_RP
  } seq_state_t;

endpackage

// File: rtl/dbs_ras_timer.sv
module dbs_ras_timer #(
  parameter int T_RAS = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic ras_ok_next
);

  localparam int CW = $clog2(T_RAS + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(T_RAS - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = arm || (cnt_q != '0);
    cnt_d  = arm ? LOAD_VAL : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // the row may close in the next cycle once at most one cycle remains
  assign ras_ok_next = (cnt_q <= CW'(1));

  a_r7_timer_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (cnt_q == LOAD_VAL));

endmodule

// File: rtl/dbs_burst_gen.sv
module dbs_burst_gen #(
  parameter int COL_W = 10,
  parameter int BL_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [COL_W-1:0] col_start,
  input  logic [BL_W-1:0]  beats,
  input  logic             step,
  output logic [COL_W-1:0] beat_col,
  output logic             last
);

  logic [COL_W-1:0] col_q;
  logic [COL_W-1:0] col_d;
  logic [BL_W-1:0]  left_q;
  logic [BL_W-1:0]  left_d;
  logic             gen_en;

  always_comb begin
    gen_en = load || step;
    if (load) begin
      col_d  = col_start;
      left_d = beats - 1'b1;
    end else begin
      col_d  = col_q + 1'b1;
      left_d = (left_q != '0) ? left_q - 1'b1 : left_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      left_q <= '0;
    end else if (gen_en) begin
      col_q  <= col_d;
      left_q <= left_d;
    end
  end

  assign beat_col = col_q;
  assign last     = (left_q == '0);

  a_r6_col_increments: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !last) |=> (beat_col == $past(beat_col) + COL_W'(1)));

  a_r5_load_not_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && step));

endmodule

// File: rtl/dbs_fsm.sv
module dbs_fsm
  import dbs_pkg::*;
#(
  parameter int ROW_W = 14,
  parameter int COL_W = 10,
  parameter int BL_W  = 16,
  parameter int T_RCD = 5,
  parameter int T_CL  = 5,
  parameter int T_RAS = 14,
  parameter int T_RP  = 5,
  parameter int AW    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [ROW_W-1:0] row_in,
  input  logic [COL_W-1:0] col_in,
  input  logic             wr_in,
  input  logic [BL_W-1:0]  len_in,
  input  logic             ras_ok_next,
  input  logic             burst_last,
  output logic             cmd_act,
  output logic             cmd_col,
  output logic             cmd_pre,
  output logic [AW-1:0]    cmd_addr,
  output logic             cmd_we,
  output logic             data_valid,
  output logic             busy,
  output logic             done,
  output logic             burst_load,
  output logic [COL_W-1:0] col_q_o,
  output logic [BL_W-1:0]  len_q_o
);

  localparam int TMAX = (T_RCD > T_CL) ? ((T_RCD > T_RP) ? T_RCD : T_RP)
                                       : ((T_CL > T_RP) ? T_CL : T_RP);
  localparam int PW = $clog2(TMAX + 1);
  localparam logic [PW-1:0] LD_RCD = PW'((T_RCD > 1) ? T_RCD - 2 : 0);
  localparam logic [PW-1:0] LD_CL  = PW'((T_CL  > 1) ? T_CL  - 2 : 0);
  localparam logic [PW-1:0] LD_RP  = PW'((T_RP  > 1) ? T_RP  - 2 : 0);

  seq_state_t state_q, state_d;
  logic [PW-1:0]    ph_q, ph_d;
  logic             ph_en;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             wr_q;
  logic [BL_W-1:0]  len_q;
  logic             accept;
  logic             done_d, done_q;

  // next-state logic
  always_comb begin
    state_d = state_q;
    ph_d    = (ph_q != '0) ? ph_q - 1'b1 : ph_q;
    ph_en   = 1'b0;
    accept  = 1'b0;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          accept  = 1'b1;
          state_d = ST_ACT;
        end
      end
      ST_ACT: begin
        if (T_RCD > 1) begin
          state_d = ST_RCD;
          ph_d    = LD_RCD;
          ph_en   = 1'b1;
        end else begin
          state_d = ST_COL;
        end
      end
      ST_RCD: begin
        ph_en = 1'b1;
        if (ph_q == '0) state_d = ST_COL;
      end
      ST_COL: begin
        if (T_CL > 1) begin
          state_d = ST_CL;
          ph_d    = LD_CL;
          ph_en   = 1'b1;
        end else begin
          state_d = ST_BURST;
        end
      end
      ST_CL: begin
        ph_en = 1'b1;
        if (ph_q == '0) state_d = ST_BURST;
      end
      ST_BURST: begin
        if (burst_last) state_d = ras_ok_next ? ST_PRE : ST_RAS;
      end
      ST_RAS: begin
        if (ras_ok_next) state_d = ST_PRE;
      end
      ST_PRE: begin
        if (T_RP > 1) begin
          state_d = ST_RP;
          ph_d    = LD_RP;
          ph_en   = 1'b1;
        end else begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      ST_RP: begin
        ph_en = 1'b1;
        if (ph_q == '0) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
    end else if (ph_en) begin
      ph_q <= ph_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
      wr_q  <= 1'b0;
      len_q <= '0;
    end else if (accept) begin
      row_q <= row_in;
      col_q <= col_in;
      wr_q  <= wr_in;
      len_q <= (len_in == '0) ? BL_W'(1) : len_in;
    end
  end

  // outputs decoded from state
  always_comb begin
    cmd_act    = (state_q == ST_ACT);
    cmd_col    = (state_q == ST_COL);
    cmd_pre    = (state_q == ST_PRE);
    cmd_we     = cmd_col && wr_q;
    data_valid = (state_q == ST_BURST);
    busy       = (state_q != ST_IDLE);
    burst_load = cmd_col;
    cmd_addr   = '0;
    if (cmd_act) cmd_addr = AW'(row_q);
    if (cmd_col) cmd_addr = AW'(col_q);
  end

  assign done    = done_q;
  assign col_q_o = col_q;
  assign len_q_o = len_q;

  // cycle distances since each command, for the timing properties
  localparam int SCW = 16;
  logic [SCW-1:0] since_act, since_col, since_pre;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_act <= '0;
      since_col <= '0;
      since_pre <= '0;
    end else begin
      since_act <= cmd_act ? SCW'(1) : ((&since_act) ? since_act : since_act + 1'b1);
      since_col <= cmd_col ? SCW'(1) : ((&since_col) ? since_col : since_col + 1'b1);
      since_pre <= cmd_pre ? SCW'(1) : ((&since_pre) ? since_pre : since_pre + 1'b1);
    end
  end

  a_r3_col_after_rcd: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_col |-> (since_act == SCW'(T_RCD)));

  a_r4_we_only_with_col: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we |-> cmd_col);

  a_r5_data_after_cl: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_valid) |-> (since_col == SCW'(T_CL)));

  a_r7_row_open_long_enough: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pre |-> (since_act >= SCW'(T_RAS)));

  a_r8_done_after_rp: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (since_pre == SCW'(T_RP)) && !busy);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_no_act_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> !cmd_act);

  a_r2_one_command: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_act, cmd_col, cmd_pre}));

endmodule

// File: rtl/dram_burst_seq.sv
module dram_burst_seq #(
  parameter int ROW_W = 14,
  parameter int COL_W = 10,
  parameter int BL_W  = 16,
  parameter int T_RCD = 5,
  parameter int T_CL  = 5,
  parameter int T_RAS = 14,
  parameter int T_RP  = 5,
  parameter int AW    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [ROW_W-1:0] row_addr,
  input  logic [COL_W-1:0] col_addr,
  input  logic             wr_req,
  input  logic [BL_W-1:0]  burst_len,
  output logic             cmd_act,
  output logic             cmd_col,
  output logic             cmd_pre,
  output logic [AW-1:0]    cmd_addr,
  output logic             cmd_we,
  output logic             data_valid,
  output logic [COL_W-1:0] beat_col,
  output logic             busy,
  output logic             done
);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             ras_ok_next;
  logic             burst_last;
  logic             burst_load;
  logic [COL_W-1:0] col_q;
  logic [BL_W-1:0]  len_q;

  // reset asserts at once and leaves in step with the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  dbs_fsm #(
    .ROW_W(ROW_W), .COL_W(COL_W), .BL_W(BL_W),
    .T_RCD(T_RCD), .T_CL(T_CL), .T_RAS(T_RAS), .T_RP(T_RP), .AW(AW)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start      (start),
    .row_in     (row_addr),
    .col_in     (col_addr),
    .wr_in      (wr_req),
    .len_in     (burst_len),
    .ras_ok_next(ras_ok_next),
    .burst_last (burst_last),
    .cmd_act    (cmd_act),
    .cmd_col    (cmd_col),
    .cmd_pre    (cmd_pre),
    .cmd_addr   (cmd_addr),
    .cmd_we     (cmd_we),
    .data_valid (data_valid),
    .busy       (busy),
    .done       (done),
    .burst_load (burst_load),
    .col_q_o    (col_q),
    .len_q_o    (len_q)
  );

  dbs_ras_timer #(.T_RAS(T_RAS)) u_ras (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .arm        (cmd_act),
    .ras_ok_next(ras_ok_next)
  );

  dbs_burst_gen #(.COL_W(COL_W), .BL_W(BL_W)) u_burst (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (burst_load),
    .col_start(col_q),
    .beats    (len_q),
    .step     (data_valid),
    .beat_col (beat_col),
    .last     (burst_last)
  );

  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_int_n |-> !busy && !done && !data_valid);

endmodule

// File: tb/dram_burst_seq_test.sv
module dram_burst_seq_test;

  localparam int ROW_W = 6;
  localparam int COL_W = 4;
  localparam int BL_W  = 10;
  localparam int T_RCD = 2;
  localparam int T_CL  = 3;
  localparam int T_RAS = 9;
  localparam int T_RP  = 2;
  localparam int AW    = (ROW_W > COL_W) ? ROW_W : COL_W;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n;
  logic             start;
  logic [ROW_W-1:0] row_addr;
  logic [COL_W-1:0] col_addr;
  logic             wr_req;
  logic [BL_W-1:0]  burst_len;
  logic             cmd_act, cmd_col, cmd_pre, cmd_we, data_valid, busy, done;
  logic [AW-1:0]    cmd_addr;
  logic [COL_W-1:0] beat_col;

  int n_chk = 0;
  int n_fail = 0;

  dram_burst_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .BL_W(BL_W),
    .T_RCD(T_RCD), .T_CL(T_CL), .T_RAS(T_RAS), .T_RP(T_RP)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .row_addr(row_addr),
    .col_addr(col_addr), .wr_req(wr_req), .burst_len(burst_len),
    .cmd_act(cmd_act), .cmd_col(cmd_col), .cmd_pre(cmd_pre),
    .cmd_addr(cmd_addr), .cmd_we(cmd_we), .data_valid(data_valid),
    .beat_col(beat_col), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // one transaction, starting at a falling edge while idle; returns at the done sample
  task automatic run_txn(input int row, input int col, input bit wr, input int len, input int inj);
    int n, a, c, v0, vl, p, d;
    int m_act, m_col, m_pre, m_done, m_busy, m_addr, m_we, m_bc, m_val, nval;
    n = (len == 0) ? 1 : len;
    a = 1;
    c = a + T_RCD;
    v0 = c + T_CL;
    vl = v0 + n - 1;
    p = (vl + 1 > a + T_RAS) ? vl + 1 : a + T_RAS;
    d = p + T_RP;
    m_act = 0; m_col = 0; m_pre = 0; m_done = 0; m_busy = 0;
    m_addr = 0; m_we = 0; m_bc = 0; m_val = 0; nval = 0;
    row_addr  = ROW_W'(row);
    col_addr  = COL_W'(col);
    wr_req    = wr;
    burst_len = BL_W'(len);
    start     = 1'b1;
    for (int idx = 1; idx <= d; idx++) begin
      @(negedge clk);
      start = (inj != 0) && (idx == inj);
      if (start) begin
        row_addr  = ~row_addr;
        col_addr  = ~col_addr;
        wr_req    = ~wr_req;
        burst_len = BL_W'(5);
      end
      if (cmd_act !== (idx == a)) m_act++;
      if (cmd_col !== (idx == c)) m_col++;
      if (cmd_pre !== (idx == p)) m_pre++;
      if (done !== (idx == d)) m_done++;
      if (busy !== (idx < d)) m_busy++;
      if (data_valid !== (idx >= v0 && idx <= vl)) m_val++;
      if (idx == a && cmd_addr !== AW'(row)) m_addr++;
      if (idx == c && cmd_addr !== AW'(col)) m_addr++;
      if (cmd_we !== ((idx == c) && wr)) m_we++;
      if (data_valid === 1'b1) begin
        nval++;
        if (beat_col !== COL_W'(col + idx - v0)) m_bc++;
      end
    end
    start = 1'b0;
    chk(m_act == 0,  "R2 activate cycle", m_act, 0);
    chk(m_busy == 0, "R2 busy window", m_busy, 0);
    chk(m_col == 0,  "R3 column command cycle", m_col, 0);
    chk(m_addr == 0, "R3 command address", m_addr, 0);
    chk(m_we == 0,   "R4 write enable", m_we, 0);
    chk(m_val == 0,  "R5 data window placement", m_val, 0);
    chk(nval == n,   "R5 beat count", nval, n);
    chk(m_bc == 0,   "R6 beat column", m_bc, 0);
    chk(m_pre == 0,  "R7 precharge cycle", m_pre, 0);
    chk(m_done == 0, "R8 done pulse", m_done, 0);
    if (inj != 0) chk(m_act == 0 && m_addr == 0 && nval == n,
                      "R9 start while busy ignored", m_act + m_addr, 0);
    if (n > 255) chk(nval == n, "R10 long burst", nval, n);
  endtask

  task automatic idle_gap(input int cycles);
    int bad;
    bad = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (busy || cmd_act || cmd_col || cmd_pre || data_valid || done) bad++;
    end
    chk(bad == 0, "R2 quiet while idle", bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    row_addr = '0;
    col_addr = '0;
    wr_req = 1'b0;
    burst_len = '0;
    repeat (3) @(negedge clk);
    chk({busy, done, data_valid, cmd_act, cmd_col, cmd_pre} == 6'b0,
        "R1 outputs in reset", int'({busy, done, data_valid, cmd_act, cmd_col, cmd_pre}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({busy, done, data_valid, cmd_act, cmd_col, cmd_pre} == 6'b0,
        "R1 outputs after reset", int'({busy, done, data_valid, cmd_act, cmd_col, cmd_pre}), 0);

    // sweep of lengths across the row-open crossover, both directions, back to back
    for (int len = 0; len <= 12; len++) begin
      for (int w = 0; w < 2; w++) begin
        run_txn((len * 7 + w) % 64, (len * 5 + w * 3 + 9) % 16, w[0], len, 0);
      end
    end
    idle_gap(3);
    run_txn(9, 14, 1'b1, 3, 2);
    run_txn(10, 15, 1'b0, 8, 7);
    idle_gap(2);
    run_txn(33, 13, 1'b0, 600, 40);
    run_txn(1, 2, 1'b1, 1023, 0);
    run_txn(62, 15, 1'b1, 1, 0);
    idle_gap(2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule